// File: doc/BRIEF.md
# Addressed Single-Output Relay Enable Updater

This block owns the eight relay-driver enable bits of a relay bank. A host reaches it through a narrow parallel port: a 3-bit output number, a level bit, and an active-low chip select that frames each write. The output number is taken at the start of the frame, when chip select falls. The level is taken at the end, when chip select rises. At that point only the chosen enable bit is rewritten, as a single-bit read-modify-write, and the other seven keep their values.

Two active-low override lines act on the whole bank. The clear line forces every enable off and beats everything else, including the set line. The set line forces every enable on and beats the parallel port. Every input is brought into the system clock domain through a synchronizer, and chip-select edges are found there. Each committed write gives a one-cycle strobe, which the power-save timing logic uses to restart its hold-off period.

Top module: `relay_addr_updater`

## Requirements
- R1: While the synchronous active-high `rst` is asserted, and on the cycle after it drops, every enable bit is 0 and `wr_stb` is 0.
- R2: The output number is taken one synchronized cycle after chip select falls. Changes to `addr` made later in the same frame do not change which bit is written. For a frame only one synchronized cycle long, the number present on that cycle is used.
- R3: When chip select rises, the level present at that moment is written. The enable bit changes on the third rising clock edge after the `cs_n` input rises: two synchronizer stages, then the register.
- R4: Output number k (natural binary, 0 to 7) selects `relay_en[k]`. A level of 1 sets that bit and a level of 0 clears it. No other enable bit changes on a write.
- R5: While chip select stays high, changes on `addr` and `lvl` leave `relay_en` unchanged and produce no strobe.
- R6: While `clr_n` is low, every enable bit is 0, whatever the state of `set_n` and the parallel port.
- R7: While `set_n` is low and `clr_n` is high, every enable bit is 1. A frame that ends during this time is dropped with no strobe, and the enables stay all ones after `set_n` is released.
- R8: `wr_stb` is high for exactly one cycle per committed write. It rises in the same cycle as the enable update and never stays high for two cycles in a row.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset (power-up clear) |
| cs_n | input | 1 | Active-low frame select; falling edge takes the output number, rising edge commits the write |
| addr | input | 3 | Output number, 0 selects bit 0 and 7 selects bit 7 |
| lvl | input | 1 | Level written to the selected enable at the end of the frame |
| set_n | input | 1 | Active-low force of all enables on |
| clr_n | input | 1 | Active-low force of all enables off; wins over `set_n` |
| relay_en | output | 8 | Relay-driver enable bits, bit k drives output k+1 |
| wr_stb | output | 1 | One-cycle pulse on each committed write |

## Verification
Four properties are checked on every cycle. A strobe cycle never changes more than one enable bit. With no strobe and no override, the enables hold. Each override forces its value. The strobe never lasts two cycles. Which bit a frame reaches, the exact commit latency, the point at which the output number is sampled inside a frame, and the dropping of frames under the set override depend on the order of stimulus, so only the bench's directed sweeps over every output number and level can show them.

// File: rtl/relay_upd_pkg.sv
`timescale 1ns/1ps
package relay_upd_pkg;

    parameter int NUM_OUT = 8;
    localparam int ADDR_W = $clog2(NUM_OUT);

    typedef logic [ADDR_W-1:0]  addr_t;
    typedef logic [NUM_OUT-1:0] en_t;

    // One committed write, produced at the end of a frame
    typedef struct packed {
        logic  valid;
        addr_t addr;
        logic  level;
    } wr_cmd_t;

    // Synchronized view of the parallel port and overrides
    typedef struct packed {
        logic  cs_n;
        logic  set_n;
        logic  clr_n;
        logic  lvl;
        addr_t addr;
    } port_t;

    localparam int PORT_W = $bits(port_t);

    function automatic en_t sel_mask(input addr_t a);
        en_t m;
        m = '0;
        m[a] = 1'b1;
        return m;
    endfunction

    function automatic en_t apply_write(input en_t cur, input wr_cmd_t c);
        en_t m;
        m = sel_mask(c.addr);
        return c.level ? (cur | m) : (cur & ~m);
    endfunction

endpackage

// File: rtl/relay_in_sync.sv
`timescale 1ns/1ps
module relay_in_sync #(
    parameter int          WIDTH   = 4,
    parameter int          STAGES  = 2,
    parameter logic [WIDTH-1:0] RST_VAL = '0
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [WIDTH-1:0] d,
    output logic [WIDTH-1:0] q
);
    logic [WIDTH-1:0] pipe [STAGES];

    genvar g;
    generate
        for (g = 0; g < STAGES; g++) begin : g_stage
            if (g == 0) begin : g_first
                always_ff @(posedge clk) begin
                    if (rst) pipe[g] <= RST_VAL;
                    else     pipe[g] <= d;
                end
            end else begin : g_next
                always_ff @(posedge clk) begin
                    if (rst) pipe[g] <= RST_VAL;
                    else     pipe[g] <= pipe[g-1];
                end
            end
        end
    endgenerate

    assign q = pipe[STAGES-1];
endmodule

// File: rtl/relay_frame_ctl.sv
`timescale 1ns/1ps
module relay_frame_ctl
    import relay_upd_pkg::*;
(
    input  logic    clk,
    input  logic    rst,
    input  logic    cs_n_s,
    input  addr_t   addr_s,
    input  logic    lvl_s,
    output wr_cmd_t cmd
);
    logic  cs_n_d;
    logic  fall_d;
    addr_t addr_q;
    logic  fall;
    logic  rise;
    addr_t addr_eff;

    assign fall = cs_n_d & ~cs_n_s;
    assign rise = ~cs_n_d & cs_n_s;

    always_ff @(posedge clk) begin
        if (rst) begin
            cs_n_d <= 1'b1;
            fall_d <= 1'b0;
            addr_q <= '0;
        end else begin
            cs_n_d <= cs_n_s;
            fall_d <= fall;
            if (fall_d) addr_q <= addr_s;
        end
    end

    // A frame one cycle long ends on the very cycle its number is taken
    assign addr_eff = fall_d ? addr_s : addr_q;

    always_comb begin
        cmd.valid = rise;
        cmd.addr  = addr_eff;
        cmd.level = lvl_s;
    end
endmodule

// File: rtl/relay_enable_reg.sv
`timescale 1ns/1ps
module relay_enable_reg
    import relay_upd_pkg::*;
(
    input  logic    clk,
    input  logic    rst,
    input  logic    set_n_s,
    input  logic    clr_n_s,
    input  wr_cmd_t cmd,
    output en_t     en,
    output logic    stb
);
    always_ff @(posedge clk) begin
        if (rst) begin
            en  <= '0;
            stb <= 1'b0;
        end else begin
            stb <= 1'b0;
            if (!clr_n_s) begin
                en <= '0;
            end else if (!set_n_s) begin
                en <= '1;
            end else if (cmd.valid) begin
                en  <= apply_write(en, cmd);
                stb <= 1'b1;
            end
        end
    end
endmodule

// File: rtl/relay_addr_updater.sv
`timescale 1ns/1ps
module relay_addr_updater
    import relay_upd_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cs_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic              lvl,
    input  logic              set_n,
    input  logic              clr_n,
    output logic [NUM_OUT-1:0] relay_en,
    output logic              wr_stb
);
    localparam port_t PORT_IDLE = '{cs_n: 1'b1, set_n: 1'b1, clr_n: 1'b1,
                                    lvl: 1'b0, addr: '0};

    port_t   raw;
    port_t   syn;
    logic [PORT_W-1:0] syn_bits;
    wr_cmd_t cmd;
    logic    set_s;
    logic    clr_s;

    always_comb begin
        raw.cs_n  = cs_n;
        raw.set_n = set_n;
        raw.clr_n = clr_n;
        raw.lvl   = lvl;
        raw.addr  = addr;
    end

    relay_in_sync #(
        .WIDTH   (PORT_W),
        .STAGES  (SYNC_STAGES),
        .RST_VAL (PORT_IDLE)
    ) i_sync (
        .clk (clk),
        .rst (rst),
        .d   (raw),
        .q   (syn_bits)
    );

    assign syn   = port_t'(syn_bits);
    assign set_s = syn.set_n;
    assign clr_s = syn.clr_n;

    relay_frame_ctl i_frame (
        .clk    (clk),
        .rst    (rst),
        .cs_n_s (syn.cs_n),
        .addr_s (syn.addr),
        .lvl_s  (syn.lvl),
        .cmd    (cmd)
    );

    relay_enable_reg i_enreg (
        .clk     (clk),
        .rst     (rst),
        .set_n_s (set_s),
        .clr_n_s (clr_s),
        .cmd     (cmd),
        .en      (relay_en),
        .stb     (wr_stb)
    );
endmodule

// File: rtl/relay_addr_updater_chk.sv
`timescale 1ns/1ps
module relay_addr_updater_chk
    import relay_upd_pkg::*;
(
    input logic clk,
    input logic rst,
    input logic set_s,
    input logic clr_s,
    input en_t  en,
    input logic stb
);
    // R4: a commit touches at most one enable bit
    p_one_bit_r4: assert property (@(posedge clk) disable iff (rst)
        stb |-> ($countones(en ^ $past(en)) <= 1));

    // R5: with no commit and no override, the enables hold
    p_hold_r5: assert property (@(posedge clk) disable iff (rst)
        (!stb && $past(set_s) && $past(clr_s)) |-> $stable(en));

    // R6: clear override forces all off
    p_clr_r6: assert property (@(posedge clk) disable iff (rst)
        $past(!clr_s) |-> (en == '0));

    // R7: set override forces all on when clear is idle
    p_set_r7: assert property (@(posedge clk) disable iff (rst)
        $past(!set_s && clr_s) |-> (en == '1));

    // R8: strobe is a single-cycle pulse
    p_strobe_pulse_r8: assert property (@(posedge clk) disable iff (rst)
        stb |=> !stb);
endmodule

bind relay_addr_updater relay_addr_updater_chk i_chk (
    .clk   (clk),
    .rst   (rst),
    .set_s (set_s),
    .clr_s (clr_s),
    .en    (relay_en),
    .stb   (wr_stb)
);

// File: tb/test_relay_addr_updater.sv
`timescale 1ns/1ps
module test_relay_addr_updater;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       cs_n = 1'b1;
    logic [2:0] addr = 3'd0;
    logic       lvl = 1'b0;
    logic       set_n = 1'b1;
    logic       clr_n = 1'b1;
    logic [7:0] relay_en;
    logic       wr_stb;

    int checks = 0;
    int errors = 0;
    int stb_cnt = 0;
    int exp_stb = 0;
    logic [7:0] model = 8'h00;
    bit done = 0;

    always #2.5 clk = ~clk;

    relay_addr_updater i_relay_addr_updater (
        .clk(clk), .rst(rst), .cs_n(cs_n), .addr(addr), .lvl(lvl),
        .set_n(set_n), .clr_n(clr_n), .relay_en(relay_en), .wr_stb(wr_stb)
    );

    always @(negedge clk) if (!rst && wr_stb) stb_cnt++;

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    // Full frame: number set up, chip select low, level, chip select high
    task automatic write_op(input logic [2:0] a, input logic l);
        addr = a; lvl = l;
        cyc(2);
        cs_n = 1'b0;
        cyc(4);
        cs_n = 1'b1;
        cyc(6);
        model[a] = l;
        exp_stb++;
    endtask

    initial begin
        #200000;
        errors++;
        $display("FAIL watchdog: actual hung expected done");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        cyc(4);
        chk("R1 en in reset", relay_en, 0);
        chk("R1 stb in reset", wr_stb, 0);
        rst = 1'b0;
        cyc(1);
        chk("R1 en after reset", relay_en, 0);
        chk("R1 stb after reset", wr_stb, 0);

        // R4: sweep every number with both levels, only one bit moves
        for (int a = 0; a < 8; a++) begin
            write_op(a[2:0], 1'b1);
            chk("R4 set sweep", relay_en, model);
        end
        for (int a = 0; a < 8; a += 2) begin
            write_op(a[2:0], 1'b0);
            chk("R4 clear even", relay_en, model);
        end
        chk("R4 pattern", relay_en, 8'hAA);
        for (int a = 7; a >= 0; a--) begin
            for (int l = 0; l < 2; l++) begin
                write_op(a[2:0], l[0]);
                chk("R4 exhaustive", relay_en, model);
            end
        end
        chk("R8 strobe count sweep", stb_cnt, exp_stb);

        // R3: exact latency of the commit
        addr = 3'd2; lvl = 1'b0;
        cyc(2);
        cs_n = 1'b0;
        cyc(4);
        cs_n = 1'b1;
        cyc(2);
        chk("R3 not yet at edge 2", relay_en, model);
        chk("R8 no strobe yet", wr_stb, 0);
        cyc(1);
        model[2] = 1'b0; exp_stb++;
        chk("R3 updated at edge 3", relay_en, model);
        chk("R8 strobe with update", wr_stb, 1);
        cyc(1);
        chk("R8 strobe one cycle", wr_stb, 0);
        cyc(4);

        // R2: number change after the fall is ignored
        addr = 3'd3; lvl = 1'b0;
        cyc(2);
        cs_n = 1'b0;
        cyc(4);
        addr = 3'd6;
        cyc(1);
        cs_n = 1'b1;
        cyc(6);
        model[3] = 1'b0; exp_stb++;
        chk("R2 late number ignored", relay_en, model);

        // R2: shortest frame uses number present then
        addr = 3'd4; lvl = 1'b0;
        cyc(2);
        cs_n = 1'b0;
        cyc(1);
        cs_n = 1'b1;
        cyc(6);
        model[4] = 1'b0; exp_stb++;
        chk("R2 one-cycle frame", relay_en, model);

        // R5: activity with chip select high does nothing
        for (int i = 0; i < 16; i++) begin
            addr = i[2:0]; lvl = i[0] ^ 1'b1;
            cyc(1);
        end
        cyc(6);
        chk("R5 idle en", relay_en, model);
        chk("R5 idle strobes", stb_cnt, exp_stb);

        // R7: set forces all on, frame during set is dropped
        set_n = 1'b0;
        cyc(4);
        chk("R7 set all", relay_en, 8'hFF);
        addr = 3'd1; lvl = 1'b0;
        cyc(2);
        cs_n = 1'b0;
        cyc(4);
        cs_n = 1'b1;
        cyc(6);
        chk("R7 frame dropped", relay_en, 8'hFF);
        chk("R7 no strobe", stb_cnt, exp_stb);
        set_n = 1'b1;
        cyc(6);
        model = 8'hFF;
        chk("R7 held after release", relay_en, model);

        // R6: clear wins over set
        set_n = 1'b0; clr_n = 1'b0;
        cyc(4);
        chk("R6 clear beats set", relay_en, 0);
        set_n = 1'b1;
        cyc(4);
        chk("R6 clear alone", relay_en, 0);
        clr_n = 1'b1;
        cyc(4);
        model = 8'h00;
        chk("R6 held after release", relay_en, model);

        write_op(3'd5, 1'b1);
        chk("R4 write after overrides", relay_en, 8'h20);
        chk("R8 total strobes", stb_cnt, exp_stb);

        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule